// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a simple synchronous host bus and a small behavioural NOR-style flash array. The host sends one-word write cycles. The block decodes them as one-write or two-write command sequences and uses them to choose what reads return: array contents, a status register, identification words, or a query table. The same sequences start single-word program and whole-block erase operations. Each operation runs on a modelled engine, which is a busy counter. The array changes only when that counter completes.

Opcodes (except the fixed erase confirm code D0h), operation lengths, identification words and the query table are parameters. Per-block write protection comes in on a pin mask. The controller supports suspending a running operation and resuming it later. While an erase is suspended, other blocks may be read and programmed. A supply-undervoltage input and the reset both return the controller to array reads and abort any running operation.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset release, or in the cycle after `uvlo` is high, reads return array data and `ready` is 1.
- R2: A first write whose low byte matches no opcode returns reads to array data.
- R3: After the status opcode, every read at any address returns the status word until another command is written. Status word layout: upper byte zero; bit 7 ready; bit 6 erase suspended; bit 5 erase error; bit 4 program error; bit 2 program suspended; bit 1 protection error; bits 3 and 0 zero.
- R4: While an operation runs (`ready` 0), every read returns the status word, whatever the selected read mode.
- R5: An erase setup write followed by a confirm write of D0h starts an erase of the block in the confirm address's top BLK_W bits. On completion, every word of that block reads FFFFh and the other blocks are unchanged.
- R6: If the second erase write is not D0h, status bits 5 and 4 are set, no erase starts, and the block data is unchanged.
- R7: A program setup write followed by a second write latches that write's address and data and starts programming. On completion, the word holds its old value ANDed with the data, because programming only clears bits.
- R8: While an operation runs, only the status and suspend opcodes take effect. Every other write is ignored: the read mode, the array and any pending sequence stay as they were.
- R9: Program or erase aimed at a block whose `wp_mask` bit is 1 does not start and leaves the data unchanged. It sets status bit 1, together with bit 4 for a program or bit 5 for an erase.
- R10: Asserting `rst_n` low during an operation aborts it. The target word keeps its old value and `ready` is 1 after release.
- R11: Suspend during an erase sets status bit 6 and raises `ready`. Arrays may then be read and other blocks programmed. Resume (D0h) continues the erase to completion. Suspend during a program sets status bit 2, and resume completes that program.
- R12: The clear-status opcode clears status bits 5, 4 and 1 without changing the read mode.
- R13: In identification mode, address bits [1:0] select the manufacturer word (0), the device word (1), or the protection bit of the addressed block in bit 0 (2). In query mode, address bits [1:0] select one 16-bit word of the query table, with word 0 in the lowest bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts any operation |
| uvlo | input | 1 | Supply undervoltage; forces array reads and aborts operations |
| wr_en | input | 1 | One-cycle bus write strobe |
| rd_en | input | 1 | One-cycle bus read strobe |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | DATA_W | Write data; low byte carries the opcode |
| wp_mask | input | 2**BLK_W | Per-block write protection |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | DATA_W | Read data |
| ready | output | 1 | No program or erase is running |

## Verification
On every cycle the assertions check four things: undervoltage recovery, status forcing while busy, the two-bit error on a bad erase confirm, and that non-status writes during an operation leave the mode and sequence alone. They also check that protected targets never start the engine and that entering erase suspend always raises ready. Data effects need the bench's scenarios. Examples are the AND behaviour of programming, erase filling a block with ones, and a suspended erase resuming to completion. Words surviving a reset abort and the identification and query words also need scenarios, because only reading the array back after a full sequence shows them.

// File: rtl/fci_pkg.sv
package fci_pkg;
    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_IDENT  = 2'd2,
        RD_QUERY  = 2'd3
    } rd_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ERASE = 2'd1,
        SEQ_PROG  = 2'd2
    } seq_e;

    localparam int SR_READY = 7;
    localparam int SR_ESUSP = 6;
    localparam int SR_EERR  = 5;
    localparam int SR_PERR  = 4;
    localparam int SR_PSUSP = 2;
    localparam int SR_PROT  = 1;

    localparam logic [7:0] ERASE_CONFIRM = 8'hD0;
endpackage

// File: rtl/fci_op_timer.sv
module fci_op_timer #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic start,
    input  logic run,
    output logic active,
    output logic done
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    assign active = q.act;
    assign done   = q.act && run && (q.cnt == CW'(LEN - 1));

    always_comb begin
        d = q;
        if (abort) begin
            d.act = 1'b0;
            d.cnt = '0;
        end else if (start) begin
            d.act = 1'b1;
            d.cnt = '0;
        end else if (done) begin
            d.act = 1'b0;
            d.cnt = '0;
        end else if (q.act && run) begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/fci_cell_array.sv
module fci_cell_array #(
    parameter int ADDR_W = 6,
    parameter int BLK_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              prog_commit,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_commit,
    input  logic [BLK_W-1:0]  erase_blk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    localparam int WORDS = 1 << ADDR_W;
    localparam int OFS_W = ADDR_W - BLK_W;

    logic [WORDS-1:0][DATA_W-1:0] flat;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam logic [BLK_W-1:0] MY_BLK = BLK_W'(w >> OFS_W);
        logic [DATA_W-1:0] cell_q;

        // Commit only at the end of an operation: an abort leaves the word as is.
        always_ff @(posedge clk) begin
            if (erase_commit && erase_blk == MY_BLK)
                cell_q <= '1;
            else if (prog_commit && prog_addr == ADDR_W'(w))
                cell_q <= cell_q & prog_data;
        end

        assign flat[w] = cell_q;
    end

    assign rd_word = flat[rd_addr];
endmodule

// File: rtl/fci_read_mux.sv
module fci_read_mux
    import fci_pkg::*;
#(
    parameter int              DATA_W    = 16,
    parameter logic [DATA_W-1:0] MFR_CODE = 16'h00A5,
    parameter logic [DATA_W-1:0] DEV_CODE = 16'h5C31,
    parameter logic [4*DATA_W-1:0] QRY_TABLE = 64'h0059_0052_0051_0001
) (
    input  rd_mode_e          mode,
    input  logic              busy,
    input  logic [1:0]        sel,
    input  logic              blk_protected,
    input  logic [7:0]        status,
    input  logic [DATA_W-1:0] array_word,
    output logic [DATA_W-1:0] word
);
    always_comb begin
        word = '0;
        if (busy || mode == RD_STATUS) begin
            word = DATA_W'(status);
        end else begin
            unique case (mode)
                RD_ARRAY: word = array_word;
                RD_IDENT: begin
                    unique case (sel)
                        2'd0:    word = MFR_CODE;
                        2'd1:    word = DEV_CODE;
                        2'd2:    word = DATA_W'(blk_protected);
                        default: word = '0;
                    endcase
                end
                RD_QUERY: word = QRY_TABLE[32'(sel) * DATA_W +: DATA_W];
                default:  word = '0;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fci_pkg::*;
#(
    parameter int ADDR_W       = 6,
    parameter int BLK_W        = 2,
    parameter int DATA_W       = 16,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 40,
    parameter logic [7:0] OP_READ    = 8'hFF,
    parameter logic [7:0] OP_STATUS  = 8'h70,
    parameter logic [7:0] OP_IDENT   = 8'h90,
    parameter logic [7:0] OP_QUERY   = 8'h98,
    parameter logic [7:0] OP_ERASE   = 8'h20,
    parameter logic [7:0] OP_PROG    = 8'h40,
    parameter logic [7:0] OP_SUSPEND = 8'hB0,
    parameter logic [7:0] OP_RESUME  = 8'hD0,
    parameter logic [7:0] OP_CLEAR   = 8'h50,
    parameter logic [DATA_W-1:0]   MFR_CODE  = 16'h00A5,
    parameter logic [DATA_W-1:0]   DEV_CODE  = 16'h5C31,
    parameter logic [4*DATA_W-1:0] QRY_TABLE = 64'h0059_0052_0051_0001
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   uvlo,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [(1<<BLK_W)-1:0]  wp_mask,
    output logic                   rd_valid,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   ready
);
    typedef struct packed {
        rd_mode_e          mode;
        seq_e              seq;
        logic              psusp;
        logic              esusp;
        logic              eerr;
        logic              perr;
        logic              prot;
        logic [ADDR_W-1:0] paddr;
        logic [DATA_W-1:0] pdata;
        logic [BLK_W-1:0]  eblk;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } ctl_t;

    ctl_t q, d;

    logic              p_act, p_done, p_start, p_run;
    logic              e_act, e_done, e_start, e_run;
    logic              busy;
    logic [7:0]        op;
    logic [BLK_W-1:0]  wblk;
    logic [7:0]        status_q;
    logic [DATA_W-1:0] array_word, mux_word;
    rd_mode_e          mode_q;
    seq_e              seq_q;

    assign op     = wdata[7:0];
    assign wblk   = addr[ADDR_W-1 -: BLK_W];
    assign busy   = (p_act && !q.psusp) || (e_act && !q.esusp);
    assign p_run  = !q.psusp;
    assign e_run  = !q.esusp && !p_act;
    assign mode_q = q.mode;
    assign seq_q  = q.seq;

    always_comb begin
        status_q = '0;
        status_q[SR_READY] = !busy;
        status_q[SR_ESUSP] = q.esusp;
        status_q[SR_EERR]  = q.eerr;
        status_q[SR_PERR]  = q.perr;
        status_q[SR_PSUSP] = q.psusp;
        status_q[SR_PROT]  = q.prot;
    end

    fci_op_timer #(.LEN(PROG_CYCLES)) u_prog_tmr (
        .clk(clk), .rst_n(rst_n), .abort(uvlo), .start(p_start),
        .run(p_run), .active(p_act), .done(p_done)
    );

    fci_op_timer #(.LEN(ERASE_CYCLES)) u_erase_tmr (
        .clk(clk), .rst_n(rst_n), .abort(uvlo), .start(e_start),
        .run(e_run), .active(e_act), .done(e_done)
    );

    fci_cell_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_cells (
        .clk(clk),
        .prog_commit(p_done), .prog_addr(q.paddr), .prog_data(q.pdata),
        .erase_commit(e_done), .erase_blk(q.eblk),
        .rd_addr(addr), .rd_word(array_word)
    );

    fci_read_mux #(
        .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE), .QRY_TABLE(QRY_TABLE)
    ) u_rmux (
        .mode(q.mode), .busy(busy), .sel(addr[1:0]),
        .blk_protected(wp_mask[wblk]), .status(status_q),
        .array_word(array_word), .word(mux_word)
    );

    always_comb begin
        d          = q;
        p_start    = 1'b0;
        e_start    = 1'b0;
        d.rd_valid = rd_en;
        d.rd_data  = rd_en ? mux_word : q.rd_data;

        if (uvlo) begin
            d.mode  = RD_ARRAY;
            d.seq   = SEQ_IDLE;
            d.psusp = 1'b0;
            d.esusp = 1'b0;
        end else if (wr_en) begin
            if (busy) begin
                // Only status selection and suspend are honoured mid-operation.
                if (op == OP_STATUS) begin
                    d.mode = RD_STATUS;
                end else if (op == OP_SUSPEND) begin
                    if (p_act && !q.psusp) begin
                        if (!p_done) begin
                            d.psusp = 1'b1;
                            d.mode  = RD_STATUS;
                        end
                    end else if (!e_done) begin
                        d.esusp = 1'b1;
                        d.mode  = RD_STATUS;
                    end
                end
            end else begin
                unique case (q.seq)
                    SEQ_ERASE: begin
                        d.seq  = SEQ_IDLE;
                        d.mode = RD_STATUS;
                        if (op != ERASE_CONFIRM) begin
                            d.eerr = 1'b1;
                            d.perr = 1'b1;
                        end else if (wp_mask[wblk]) begin
                            d.eerr = 1'b1;
                            d.prot = 1'b1;
                        end else begin
                            e_start = 1'b1;
                            d.eblk  = wblk;
                        end
                    end
                    SEQ_PROG: begin
                        d.seq  = SEQ_IDLE;
                        d.mode = RD_STATUS;
                        if (wp_mask[wblk] || (q.esusp && wblk == q.eblk)) begin
                            d.perr = 1'b1;
                            d.prot = 1'b1;
                        end else begin
                            p_start = 1'b1;
                            d.paddr = addr;
                            d.pdata = wdata;
                        end
                    end
                    default: begin
                        if (op == OP_READ) begin
                            d.mode = RD_ARRAY;
                        end else if (op == OP_STATUS) begin
                            d.mode = RD_STATUS;
                        end else if (op == OP_IDENT) begin
                            d.mode = RD_IDENT;
                        end else if (op == OP_QUERY) begin
                            d.mode = RD_QUERY;
                        end else if (op == OP_CLEAR) begin
                            d.eerr = 1'b0;
                            d.perr = 1'b0;
                            d.prot = 1'b0;
                        end else if (op == OP_ERASE && !q.esusp && !q.psusp) begin
                            d.seq = SEQ_ERASE;
                        end else if (op == OP_PROG && !q.psusp) begin
                            d.seq = SEQ_PROG;
                        end else if (op == OP_RESUME && q.psusp) begin
                            d.psusp = 1'b0;
                            d.mode  = RD_STATUS;
                        end else if (op == OP_RESUME && q.esusp) begin
                            d.esusp = 1'b0;
                            d.mode  = RD_STATUS;
                        end else begin
                            d.mode = RD_ARRAY;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.mode <= RD_ARRAY;
            q.seq  <= SEQ_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rd_valid = q.rd_valid;
    assign rd_data  = q.rd_data;
    assign ready    = !busy;
endmodule

// File: rtl/fci_checker.sv
module fci_checker
    import fci_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BLK_W  = 2,
    parameter int DATA_W = 16,
    parameter logic [7:0] OP_STATUS  = 8'h70,
    parameter logic [7:0] OP_SUSPEND = 8'hB0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  uvlo,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [ADDR_W-1:0]     addr,
    input logic [7:0]            op,
    input logic [(1<<BLK_W)-1:0] wp_mask,
    input logic                  rd_valid,
    input logic [DATA_W-1:0]     rd_data,
    input logic                  ready,
    input rd_mode_e              mode_q,
    input seq_e                  seq_q,
    input logic [7:0]            status_q
);
    logic tgt_prot;
    assign tgt_prot = wp_mask[addr[ADDR_W-1 -: BLK_W]];

    p_uvlo_array_r1: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (mode_q == RD_ARRAY) && (seq_q == SEQ_IDLE) && ready);

    p_rd_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_status_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && mode_q == RD_STATUS) |=> (rd_data[DATA_W-1:8] == '0));

    p_busy_reads_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !ready) |=> (rd_data[DATA_W-1:8] == '0) && !rd_data[SR_READY]);

    p_bad_confirm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!uvlo && wr_en && ready && seq_q == SEQ_ERASE && op != ERASE_CONFIRM)
        |=> status_q[SR_EERR] && status_q[SR_PERR] && ready);

    p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!uvlo && wr_en && !ready && op != OP_STATUS && op != OP_SUSPEND)
        |=> $stable(mode_q) && (seq_q == SEQ_IDLE));

    p_prot_prog_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!uvlo && wr_en && ready && seq_q == SEQ_PROG && tgt_prot)
        |=> ready && status_q[SR_PROT] && status_q[SR_PERR]);

    p_prot_erase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!uvlo && wr_en && ready && seq_q == SEQ_ERASE && op == ERASE_CONFIRM && tgt_prot)
        |=> ready && status_q[SR_PROT] && status_q[SR_EERR]);

    p_esusp_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[SR_ESUSP]) |-> ready);
endmodule

bind flash_cmd_ctrl fci_checker #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(DATA_W),
    .OP_STATUS(OP_STATUS), .OP_SUSPEND(OP_SUSPEND)
) u_chk (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .op(op), .wp_mask(wp_mask), .rd_valid(rd_valid),
    .rd_data(rd_data), .ready(ready), .mode_q(mode_q), .seq_q(seq_q),
    .status_q(status_q)
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
    localparam logic [7:0] C_READ = 8'hFF, C_STAT = 8'h70, C_IDENT = 8'h90, C_QRY = 8'h98;
    localparam logic [7:0] C_ERASE = 8'h20, C_PROG = 8'h40, C_SUSP = 8'hB0, C_RES = 8'hD0;
    localparam logic [7:0] C_CLR = 8'h50, C_CONF = 8'hD0;
    localparam int WATCHDOG = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uvlo = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [3:0]  wp_mask = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        ready;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] exp_v;
    string       tag_v;

    always #5 clk = ~clk;

    flash_cmd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .wp_mask(wp_mask), .rd_valid(rd_valid),
        .rd_data(rd_data), .ready(ready)
    );

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: run reached cycle %0d, expected end before %0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    // Monitor: compares each returned read against the scoreboard queue.
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                tests++;
                fails++;
                $display("FAIL scoreboard: got %h, expected no read", rd_data);
            end else begin
                exp_v = exp_q.pop_front();
                tag_v = tag_q.pop_front();
                tests++;
                if (rd_data !== exp_v) begin
                    fails++;
                    $display("FAIL %s: got %h expected %h", tag_v, rd_data, exp_v);
                end
            end
        end
    end

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] dat);
        @(negedge clk);
        addr = a; wdata = dat; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!ready) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk({15'd0, ready}, 16'd1, "R1 ready after reset");
        chk({15'd0, rd_valid}, 16'd0, "R1 no read data after reset");

        for (int b = 0; b < 4; b++) begin
            wr(6'(b * 16), {8'h00, C_ERASE});
            wr(6'(b * 16), {8'h00, C_CONF});
            wait_ready();
        end
        rd(6'h00, 16'h0080, "R5 status after erase");
        wr(6'h00, {8'h00, C_READ});
        rd(6'h13, 16'hFFFF, "R5 erased word");

        // Program, busy read, AND behaviour
        wr(6'h05, {8'h00, C_PROG});
        wr(6'h05, 16'h1234);
        rd(6'h20, 16'h0000, "R4 read while busy");
        wait_ready();
        rd(6'h05, 16'h0080, "R7 status after program");
        wr(6'h00, {8'h00, C_READ});
        rd(6'h05, 16'h1234, "R7 programmed word");
        wr(6'h05, {8'h00, C_PROG});
        wr(6'h05, 16'hFF0F);
        wait_ready();
        wr(6'h00, {8'h00, C_READ});
        rd(6'h05, 16'h1204, "R7 program only clears bits");

        // Status mode at any address
        wr(6'h11, {8'h00, C_STAT});
        rd(6'h33, 16'h0080, "R3 status at 33h");
        rd(6'h05, 16'h0080, "R3 status at 05h");

        // Identification and query
        wp_mask = 4'b0100;
        wr(6'h00, {8'h00, C_IDENT});
        rd(6'h00, 16'h00A5, "R13 manufacturer");
        rd(6'h01, 16'h5C31, "R13 device");
        rd(6'h22, 16'h0001, "R13 protected block bit");
        rd(6'h02, 16'h0000, "R13 unprotected block bit");
        wp_mask = 4'b0000;
        wr(6'h00, {8'h00, C_QRY});
        rd(6'h00, 16'h0001, "R13 query word 0");
        rd(6'h01, 16'h0051, "R13 query word 1");
        rd(6'h03, 16'h0059, "R13 query word 3");

        // Invalid opcode returns to array reads
        wr(6'h00, 16'h0012);
        rd(6'h05, 16'h1204, "R2 invalid opcode gives array");

        // Bad confirm
        wr(6'h13, {8'h00, C_PROG});
        wr(6'h13, 16'h00FF);
        wait_ready();
        wr(6'h10, {8'h00, C_ERASE});
        wr(6'h10, 16'h0010);
        chk({15'd0, ready}, 16'd1, "R6 no erase started");
        rd(6'h10, 16'h00B0, "R6 bits 5 and 4 set");
        wr(6'h00, {8'h00, C_READ});
        rd(6'h13, 16'h00FF, "R6 block data kept");
        wr(6'h00, {8'h00, C_STAT});
        wr(6'h00, {8'h00, C_CLR});
        rd(6'h00, 16'h0080, "R12 clear status keeps status mode");

        // Protected targets
        wp_mask = 4'b0100;
        wr(6'h25, {8'h00, C_PROG});
        wr(6'h25, 16'h0000);
        chk({15'd0, ready}, 16'd1, "R9 protected program not started");
        rd(6'h25, 16'h0092, "R9 protected program status");
        wr(6'h00, {8'h00, C_CLR});
        wr(6'h20, {8'h00, C_ERASE});
        wr(6'h20, {8'h00, C_CONF});
        rd(6'h20, 16'h00A2, "R9 protected erase status");
        wr(6'h00, {8'h00, C_CLR});
        wr(6'h00, {8'h00, C_READ});
        rd(6'h25, 16'hFFFF, "R9 protected word unchanged");
        wp_mask = 4'b0000;

        // Writes ignored while erasing block 3
        wr(6'h30, {8'h00, C_ERASE});
        wr(6'h30, {8'h00, C_CONF});
        wr(6'h00, {8'h00, C_READ});
        wr(6'h05, {8'h00, C_PROG});
        wr(6'h05, 16'h0000);
        wait_ready();
        rd(6'h05, 16'h0080, "R8 read command ignored while busy");
        wr(6'h00, {8'h00, C_READ});
        rd(6'h05, 16'h1204, "R8 program ignored while busy");

        // Erase suspend with program in another block
        wr(6'h30, {8'h00, C_PROG});
        wr(6'h30, 16'h0000);
        wait_ready();
        wr(6'h30, {8'h00, C_ERASE});
        wr(6'h30, {8'h00, C_CONF});
        wr(6'h30, {8'h00, C_SUSP});
        wait_ready();
        rd(6'h30, 16'h00C0, "R11 erase suspended status");
        wr(6'h00, {8'h00, C_READ});
        rd(6'h30, 16'h0000, "R11 erase not finished while suspended");
        wr(6'h14, {8'h00, C_PROG});
        wr(6'h14, 16'h5A5A);
        wait_ready();
        rd(6'h14, 16'h00C0, "R11 status after program in suspend");
        wr(6'h00, {8'h00, C_READ});
        rd(6'h14, 16'h5A5A, "R11 program in other block");
        wr(6'h00, {8'h00, C_RES});
        chk({15'd0, ready}, 16'd0, "R11 erase resumed");
        wait_ready();
        wr(6'h00, {8'h00, C_READ});
        rd(6'h30, 16'hFFFF, "R11 erase completed after resume");

        // Program suspend
        wr(6'h06, {8'h00, C_PROG});
        wr(6'h06, 16'h00F0);
        wr(6'h06, {8'h00, C_SUSP});
        wait_ready();
        rd(6'h06, 16'h0084, "R11 program suspended status");
        wr(6'h00, {8'h00, C_READ});
        rd(6'h21, 16'hFFFF, "R11 read other block in program suspend");
        rd(6'h06, 16'hFFFF, "R11 program not committed while suspended");
        wr(6'h00, {8'h00, C_RES});
        wait_ready();
        wr(6'h00, {8'h00, C_READ});
        rd(6'h06, 16'h00F0, "R11 program completed after resume");

        // Reset during program
        wr(6'h07, {8'h00, C_PROG});
        wr(6'h07, 16'h0000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk({15'd0, ready}, 16'd1, "R10 ready after reset abort");
        rd(6'h07, 16'hFFFF, "R10 word unchanged after abort");

        // Undervoltage returns to array reads
        wr(6'h00, {8'h00, C_STAT});
        @(negedge clk);
        uvlo = 1'b1;
        @(negedge clk);
        uvlo = 1'b0;
        rd(6'h07, 16'hFFFF, "R1 array after undervoltage");

        repeat (4) @(negedge clk);
        chk(16'(exp_q.size()), 16'd0, "scoreboard drained");
        summary();
        $finish;
    end
endmodule